// File: doc/BRIEF.md
# Bowling Score Sequencer

This block is the control core of a bowling score keeper. A player's throw is announced by raising a level switch while the knocked-down pin count sits on a 4-bit input. The block synchronises the switch, turns each rising edge into a single update pulse, captures the pin count on that pulse, and decides whether the throw is a strike or a spare. It tracks the frame number and carries the bonus credit owed by earlier strikes and spares.

Scoring is done by an external accumulator, which adds `add_val_o` once for every cycle in which `add_en_o` is high. The sequencer holds `add_en_o` for as many cycles as the current throw has to be counted. That is one base count for a regular throw, plus one for each strike still inside its two-throw credit window and one for a spare still inside its one-throw window. After the tenth frame the block takes bonus throws, which carry only their owed credit, until no credit remains. It then raises `done_o` and holds it until reset.

Top module: `bowl_seq_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, `add_en_o` is 0, `done_o` is 0 and `frame_o` is 0 until the first throw is taken.
- R2: The switch passes through a two-stage synchroniser. Each 0-to-1 change of the switch starts exactly one throw. Holding the switch high starts no further throw.
- R3: The pin count is captured only on the update pulse. A value above 10 is treated as 10.
- R4: A first throw of 10 pins is a strike. It ends the frame at once, and the next switch rise is the first throw of the next frame.
- R5: A second throw is a spare when its count plus the count captured on that frame's first throw equals 10.
- R6: A regular throw holds `add_en_o` high for exactly 1 + s1 + s0 + sp consecutive cycles. Here s1 and s0 are the two strike-history bits and sp is the spare bit, all taken before the throw updates them.
- R7: Every throw shifts the strike history (s1 into s0, the new bit into s1, the old s0 dropped) and rewrites sp. A first throw enters its strike result and clears sp. A second throw enters 0 and sets sp to its spare result. A bonus throw enters 0 into both.
- R8: After frame 10, bonus throws are taken while s1, s0 and sp are not all 0. Each bonus throw holds `add_en_o` for only s1 + s0 + sp cycles, with no base count.
- R9: `done_o` rises once the credit is drained after frame 10 and stays high until reset. While it is high, switch rises cause no addition.
- R10: `frame_o` starts at 0, rises by exactly 1 at the end of each of the first nine frames, and never exceeds 9.
- R11: An accumulator that sums `add_val_o` over the enable cycles reaches the standard game total: 114 for the sample game, 300 for twelve strikes, 150 for twenty-one fives and 70 for ten open 3/4 frames.
- R12: During an enable burst, `add_val_o` equals the captured and clamped pin count and does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| throw_sw_i | input | 1 | Level switch; a rise announces a throw |
| pins_i | input | 4 | Pins knocked down by the throw being announced |
| add_en_o | output | 1 | Accumulator add enable, one addition per cycle |
| add_val_o | output | 4 | Captured pin count to be added |
| frame_o | output | 4 | Current frame, 0 to 9 |
| done_o | output | 1 | Game finished |

## Verification
The assertions check on every cycle the properties that hold in any game:
- the update pulse never lasts two cycles;
- the captured value stays at or below 10 and is steady inside a burst;
- no burst is longer than four cycles;
- the frame number only steps by one and stays in range;
- done is sticky and never coincides with an addition.

The exact burst length of each throw, the bonus credit after frame 10, the moment the game ends and the final totals depend on the whole throw history. Only the bench's scenarios can show these: four complete games, a clamped strike and switch presses after the end, with each burst compared against a weight computed from the standard scoring rules.

// File: rtl/bowl_pkg.sv
package bowl_pkg;

  typedef enum logic [3:0] {
    ST_WAIT_T1,
    ST_GAP_T1,
    ST_ADD_T1,
    ST_WAIT_T2,
    ST_GAP_T2,
    ST_ADD_T2,
    ST_FRAME_END,
    ST_BONUS_CHK,
    ST_WAIT_BN,
    ST_ADD_BN,
    ST_DONE
  } seq_state_t;

  typedef enum logic [1:0] {
    TK_FIRST,
    TK_SECOND,
    TK_BONUS
  } throw_kind_t;

endpackage

// File: rtl/bowl_edge_sync.sv
module bowl_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= lvl_i;
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= sync_q[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/bowl_pin_reg.sv
module bowl_pin_reg #(
  parameter int PIN_W    = 4,
  parameter int MAX_PINS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [PIN_W-1:0] pins_i,
  output logic [PIN_W-1:0] pins_q_o
);

  localparam logic [PIN_W-1:0] PIN_MAX = PIN_W'(MAX_PINS);

  logic [PIN_W-1:0] pins_d;
  logic [PIN_W-1:0] pins_q;

  always_comb begin
    pins_d = pins_q;
    if (load_i) pins_d = (pins_i > PIN_MAX) ? PIN_MAX : pins_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pins_q <= '0;
    else        pins_q <= pins_d;
  end

  assign pins_q_o = pins_q;

endmodule

// File: rtl/bowl_mark_track.sv
module bowl_mark_track
  import bowl_pkg::*;
#(
  parameter int PIN_W        = 4,
  parameter int MAX_PINS     = 10,
  parameter int STRIKE_DEPTH = 2,
  parameter int EXTRA_W      = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PIN_W-1:0]   pins_i,
  input  throw_kind_t        kind_i,
  input  logic               store_i,
  input  logic               shift_i,
  output logic               hit_o,
  output logic [EXTRA_W-1:0] extra_o,
  output logic               empty_o
);

  localparam logic [PIN_W:0] SUM_MAX = (PIN_W+1)'(MAX_PINS);
  localparam logic [PIN_W-1:0] PIN_MAX = PIN_W'(MAX_PINS);

  logic [PIN_W-1:0]        first_q;
  logic [PIN_W:0]          pair_sum;
  logic [STRIKE_DEPTH-1:0] strike_q;
  logic                    spare_q;
  logic                    new_strike;
  logic                    new_spare;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       first_q <= '0;
    else if (store_i) first_q <= pins_i;
  end

  assign pair_sum = {1'b0, first_q} + {1'b0, pins_i};

  always_comb begin
    case (kind_i)
      TK_FIRST:  hit_o = (pins_i == PIN_MAX);
      TK_SECOND: hit_o = (pair_sum == SUM_MAX);
      default:   hit_o = 1'b0;
    endcase
  end

  assign new_strike = (kind_i == TK_FIRST)  & hit_o;
  assign new_spare  = (kind_i == TK_SECOND) & hit_o;

  for (genvar g = 0; g < STRIKE_DEPTH; g++) begin : g_hist
    if (g == 0) begin : g_newest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       strike_q[0] <= 1'b0;
        else if (shift_i) strike_q[0] <= new_strike;
      end
    end else begin : g_older
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       strike_q[g] <= 1'b0;
        else if (shift_i) strike_q[g] <= strike_q[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       spare_q <= 1'b0;
    else if (shift_i) spare_q <= new_spare;
  end

  always_comb begin
    extra_o = EXTRA_W'(spare_q);
    for (int k = 0; k < STRIKE_DEPTH; k++) begin
      extra_o = extra_o + EXTRA_W'(strike_q[k]);
    end
  end

  assign empty_o = (strike_q == '0) && !spare_q;

endmodule

// File: rtl/bowl_frame_ctr.sv
module bowl_frame_ctr #(
  parameter int FRAMES  = 10,
  parameter int FRAME_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inc_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               last_o
);

  localparam logic [FRAME_W-1:0] LAST_IDX = FRAME_W'(FRAMES - 1);

  logic [FRAME_W-1:0] frame_q;
  logic [FRAME_W-1:0] frame_d;

  always_comb begin
    frame_d = frame_q;
    if (inc_i && (frame_q != LAST_IDX)) frame_d = frame_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_q <= '0;
    else        frame_q <= frame_d;
  end

  assign frame_o = frame_q;
  assign last_o  = (frame_q == LAST_IDX);

endmodule

// File: rtl/bowl_seq_ctrl.sv
module bowl_seq_ctrl
  import bowl_pkg::*;
#(
  parameter int PIN_W        = 4,
  parameter int MAX_PINS     = 10,
  parameter int FRAMES       = 10,
  parameter int STRIKE_DEPTH = 2,
  parameter int SYNC_STAGES  = 2,
  parameter int FRAME_W      = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               throw_sw_i,
  input  logic [PIN_W-1:0]   pins_i,
  output logic               add_en_o,
  output logic [PIN_W-1:0]   add_val_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               done_o
);

  localparam int EXTRA_W = $clog2(STRIKE_DEPTH + 2);
  localparam logic [EXTRA_W-1:0] ONE_X = EXTRA_W'(1);

  logic [1:0]         rst_pipe;
  logic               arst_n;
  logic               upd;
  logic [PIN_W-1:0]   pins_q;
  logic               hit;
  logic [EXTRA_W-1:0] extra;
  logic               hist_empty;
  logic               last_frame;
  seq_state_t         state_q, state_d;
  logic [EXTRA_W-1:0] cnt_q, cnt_d;
  logic               shift_en;
  logic               store_first;
  logic               frame_inc;
  throw_kind_t        kind;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign arst_n = rst_pipe[1];

  bowl_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (arst_n),
    .lvl_i  (throw_sw_i),
    .rise_o (upd)
  );

  bowl_pin_reg #(.PIN_W(PIN_W), .MAX_PINS(MAX_PINS)) u_pins (
    .clk      (clk),
    .rst_n    (arst_n),
    .load_i   (upd),
    .pins_i   (pins_i),
    .pins_q_o (pins_q)
  );

  bowl_mark_track #(
    .PIN_W(PIN_W), .MAX_PINS(MAX_PINS),
    .STRIKE_DEPTH(STRIKE_DEPTH), .EXTRA_W(EXTRA_W)
  ) u_marks (
    .clk     (clk),
    .rst_n   (arst_n),
    .pins_i  (pins_q),
    .kind_i  (kind),
    .store_i (store_first),
    .shift_i (shift_en),
    .hit_o   (hit),
    .extra_o (extra),
    .empty_o (hist_empty)
  );

  bowl_frame_ctr #(.FRAMES(FRAMES), .FRAME_W(FRAME_W)) u_frames (
    .clk     (clk),
    .rst_n   (arst_n),
    .inc_i   (frame_inc),
    .frame_o (frame_o),
    .last_o  (last_frame)
  );

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    shift_en    = 1'b0;
    store_first = 1'b0;
    frame_inc   = 1'b0;
    add_en_o    = 1'b0;
    kind        = TK_BONUS;
    case (state_q)
      ST_WAIT_T1: if (upd) state_d = ST_GAP_T1;
      ST_GAP_T1: begin
        state_d = ST_ADD_T1;
        cnt_d   = extra;
      end
      ST_ADD_T1: begin
        add_en_o = 1'b1;
        kind     = TK_FIRST;
        if (cnt_q == '0) begin
          shift_en    = 1'b1;
          store_first = 1'b1;
          state_d     = hit ? ST_FRAME_END : ST_WAIT_T2;
        end else begin
          cnt_d = cnt_q - ONE_X;
        end
      end
      ST_WAIT_T2: if (upd) state_d = ST_GAP_T2;
      ST_GAP_T2: begin
        state_d = ST_ADD_T2;
        cnt_d   = extra;
      end
      ST_ADD_T2: begin
        add_en_o = 1'b1;
        kind     = TK_SECOND;
        if (cnt_q == '0) begin
          shift_en = 1'b1;
          state_d  = ST_FRAME_END;
        end else begin
          cnt_d = cnt_q - ONE_X;
        end
      end
      ST_FRAME_END: begin
        if (last_frame) begin
          state_d = ST_BONUS_CHK;
        end else begin
          frame_inc = 1'b1;
          state_d   = ST_WAIT_T1;
        end
      end
      ST_BONUS_CHK: state_d = hist_empty ? ST_DONE : ST_WAIT_BN;
      ST_WAIT_BN: begin
        if (upd) begin
          state_d = ST_ADD_BN;
          cnt_d   = extra - ONE_X;
        end
      end
      ST_ADD_BN: begin
        add_en_o = 1'b1;
        if (cnt_q == '0) begin
          shift_en = 1'b1;
          state_d  = ST_BONUS_CHK;
        end else begin
          cnt_d = cnt_q - ONE_X;
        end
      end
      ST_DONE: state_d = ST_DONE;
      default: state_d = ST_WAIT_T1;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= ST_WAIT_T1;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign add_val_o = pins_q;
  assign done_o    = (state_q == ST_DONE);

endmodule

// File: rtl/bowl_seq_ctrl_chk.sv
module bowl_seq_ctrl_chk #(
  parameter int PIN_W        = 4,
  parameter int MAX_PINS     = 10,
  parameter int FRAMES       = 10,
  parameter int STRIKE_DEPTH = 2,
  parameter int FRAME_W      = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               upd_i,
  input logic               add_en_i,
  input logic [PIN_W-1:0]   add_val_i,
  input logic [FRAME_W-1:0] frame_i,
  input logic               done_i
);

  localparam int MAX_BURST = 2 + STRIKE_DEPTH;

  int unsigned run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_q <= 0;
    else if (add_en_i) run_q <= run_q + 1;
    else               run_q <= 0;
  end

  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i |=> !upd_i);

  p_val_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    add_en_i |-> (add_val_i <= PIN_W'(MAX_PINS)));

  p_val_steady_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (add_en_i && $past(add_en_i)) |-> $stable(add_val_i));

  p_burst_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= MAX_BURST);

  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> done_i);

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |-> !add_en_i);

  p_frame_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_i <= FRAME_W'(FRAMES - 1));

  p_frame_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_i != $past(frame_i)) |-> (frame_i == $past(frame_i) + 1'b1));

endmodule

bind bowl_seq_ctrl bowl_seq_ctrl_chk #(
  .PIN_W(PIN_W), .MAX_PINS(MAX_PINS), .FRAMES(FRAMES),
  .STRIKE_DEPTH(STRIKE_DEPTH), .FRAME_W(FRAME_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .upd_i     (upd),
  .add_en_i  (add_en_o),
  .add_val_i (add_val_o),
  .frame_i   (frame_o),
  .done_i    (done_o)
);

// File: tb/tb_bowl_seq_ctrl.sv
`timescale 1ns/1ps
module tb_bowl_seq_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       throw_sw_i;
  logic [3:0] pins_i;
  logic       add_en_o;
  logic [3:0] add_val_o;
  logic [3:0] frame_o;
  logic       done_o;

  always #5 clk = ~clk;

  bowl_seq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .throw_sw_i(throw_sw_i), .pins_i(pins_i),
    .add_en_o(add_en_o), .add_val_o(add_val_o), .frame_o(frame_o), .done_o(done_o)
  );

  typedef struct { int pins; int weight; } exp_t;
  exp_t sbq[$];

  int checks = 0;
  int fails  = 0;
  int score  = 0;
  int run    = 0;
  int run_val = 0;
  int game_t[0:23];
  int game_w[0:23];
  int game_n;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: one burst per throw
  always @(negedge clk) begin
    if (!rst_n) begin
      run = 0;
    end else if (add_en_o) begin
      if (run > 0)
        check(int'(add_val_o) == run_val, "R12", "value changed in burst",
              int'(add_val_o), run_val);
      run_val = int'(add_val_o);
      run++;
      score += int'(add_val_o);
    end else if (run > 0) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R9", "burst with no throw expected", run, 0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check(run == e.weight, "R6 R8", "burst length", run, e.weight);
        check(run_val == e.pins, "R3 R12", "burst value", run_val, e.pins);
      end
      run = 0;
    end
  end

  function automatic int clampv(input int p);
    return (p > 10) ? 10 : p;
  endfunction

  // independent standard-rule weights for game_t[0:game_n-1]
  task automatic calc_weights();
    int i;
    for (int k = 0; k < 24; k++) game_w[k] = 0;
    i = 0;
    for (int f = 0; f < 10; f++) begin
      if (clampv(game_t[i]) == 10) begin
        game_w[i]++; game_w[i+1]++; game_w[i+2]++;
        i = i + 1;
      end else begin
        game_w[i]++; game_w[i+1]++;
        if (clampv(game_t[i]) + clampv(game_t[i+1]) == 10) game_w[i+2]++;
        i = i + 2;
      end
    end
  endtask

  task automatic do_throw(input int p, input int hold);
    @(negedge clk);
    pins_i = p[3:0];
    throw_sw_i = 1'b1;
    repeat (hold) @(negedge clk);
    throw_sw_i = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic push_throw(input int idx);
    exp_t e;
    e.pins = clampv(game_t[idx]);
    e.weight = game_w[idx];
    sbq.push_back(e);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    throw_sw_i = 1'b0;
    pins_i = 4'd0;
    repeat (4) @(negedge clk);
    check(add_en_o == 1'b0 && done_o == 1'b0 && frame_o == 4'd0, "R1",
          "outputs during reset", {add_en_o, done_o, frame_o}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    score = 0;
    sbq.delete();
    check(add_en_o == 1'b0 && done_o == 1'b0 && frame_o == 4'd0, "R1",
          "outputs after reset", {add_en_o, done_o, frame_o}, 0);
  endtask

  task automatic play_game(input string tag, input int exp_score);
    calc_weights();
    for (int i = 0; i < game_n; i++) begin
      if (i == game_n - 1)
        check(done_o == 1'b0, "R9", "done before last throw", done_o, 0);
      push_throw(i);
      do_throw(game_t[i], 6);
    end
    repeat (10) @(negedge clk);
    check(done_o == 1'b1, "R9", "done after game", done_o, 1);
    check(sbq.size() == 0, "R8", "throws left unscored", sbq.size(), 0);
    check(score == exp_score, "R11", tag, score, exp_score);
  endtask

  task automatic set_list(input int n, input int v);
    game_n = n;
    for (int k = 0; k < 24; k++) game_t[k] = v;
  endtask

  initial begin
    do_reset();

    // sample game: spares, strikes, open frames, two bonus throws
    set_list(20, 0);
    game_t[0]=0;  game_t[1]=10; game_t[2]=6;  game_t[3]=1;  game_t[4]=4;
    game_t[5]=5;  game_t[6]=0;  game_t[7]=6;  game_t[8]=6;  game_t[9]=4;
    game_t[10]=10; game_t[11]=0; game_t[12]=0; game_t[13]=10; game_t[14]=3;
    game_t[15]=5; game_t[16]=10; game_t[17]=8; game_t[18]=2; game_t[19]=10;
    // game ends after the first two bonus throws; index 19 is unused
    game_n = 19;
    play_game("R5 sample game total", 114);

    // perfect game: R4 strikes, R8 two bonus throws
    do_reset();
    set_list(12, 10);
    play_game("R4 R8 perfect game total", 300);

    // all spares of five: R5 R7 one bonus throw
    do_reset();
    set_list(21, 5);
    play_game("R5 R7 all-spare total", 150);

    // open frames with frame tracking, long switch hold, presses after done
    do_reset();
    set_list(20, 0);
    for (int f = 0; f < 10; f++) begin
      game_t[2*f] = 3; game_t[2*f+1] = 4;
    end
    calc_weights();
    for (int f = 0; f < 10; f++) begin
      push_throw(2*f);
      do_throw(3, (f == 0) ? 40 : 6);
      if (f == 0)
        check(frame_o == 4'd0 && sbq.size() == 0, "R2",
              "held switch, frame after first throw", frame_o, 0);
      push_throw(2*f+1);
      do_throw(4, 6);
      if (f < 9)
        check(frame_o == 4'(f + 1), "R10", "frame after pair", frame_o, f + 1);
      else
        check(frame_o == 4'd9, "R10", "frame stays at last", frame_o, 9);
    end
    repeat (6) @(negedge clk);
    check(done_o == 1'b1, "R9", "done with no bonus", done_o, 1);
    check(score == 70, "R11", "open game total", score, 70);
    do_throw(10, 6);
    do_throw(7, 6);
    check(score == 70 && done_o == 1'b1, "R9", "presses after done", score, 70);

    // clamped strike: 15 counts as a strike of 10
    do_reset();
    set_list(19, 0);
    game_t[0] = 15;
    calc_weights();
    for (int i = 0; i < game_n; i++) begin
      push_throw(i);
      do_throw(game_t[i], 6);
      if (i == 0)
        check(frame_o == 4'd1, "R3 R4", "clamped strike ends frame", frame_o, 1);
    end
    repeat (10) @(negedge clk);
    check(done_o == 1'b1, "R9", "done after clamped game", done_o, 1);
    check(score == 10, "R3", "clamped game total", score, 10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule